// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Queueing

This block is the transmit side of a UART-style serial port. Software writes a byte, or a nine-bit word, into a one-entry holding buffer. When a bit-rate tick arrives and the shifter is free, the buffer contents move into a shift register. The shift register then drives a framed character onto one serial output line, one bit per tick. The bit-rate tick comes from a separate baud generator, which is not part of this block.

The enable input does more than gate the shifter. Each 0-to-1 transition of the enable schedules one idle character. An idle character is a full character time of marking level with no framing. This gives a synchronizing preamble when the port is first enabled. It also gives an extra idle gap when the enable is pulsed low and back high while a character is on the line. Clearing the enable lets the current character finish and then leaves the line idle. A polarity control inverts every level the line shows.

An empty flag reports when the buffer can accept another write. Together with an interrupt mask it forms an interrupt request. A completion flag reports when nothing at all is left to send.

Top module: `async_tx_core`

## Requirements
- R1: After reset `txd` is 1 (with `tx_inv` = 0), `tx_empty` is 1, `tx_done` is 1 and `irq` equals `tie`.
- R2: While no character is shifting, `txd` holds the idle level, which is 1 XOR `tx_inv`.
- R3: On a 0-to-1 transition of `tx_en`, one idle character is sent before any buffered data. The idle character is all ones for 10 bit times (`nine_bit` = 0) or 11 bit times (`nine_bit` = 1).
- R4: A data character is sent as follows, in this order: a start bit of 0; `din[7:0]` least significant bit first; `din[8]` only when `nine_bit` = 1; then a stop bit of 1. Each bit lasts one `bit_tick` period. A buffered character follows the previous one with no gap.
- R5: A pulse on `wr` clears `tx_empty` on the next clock. `tx_empty` returns to 1 on the `bit_tick` that moves the buffer into the shift register.
- R6: `irq` is 1 exactly when `tx_empty` = 1 and `tie` = 1.
- R7: Clearing `tx_en` while a character is shifting lets that character finish. The line then stays idle, and a buffered byte stays held (`tx_empty` = 0, `tx_done` = 0).
- R8: If `tx_en` falls and rises again before the stop bit of the current character is on the line, one idle character is sent after the current character, followed by the buffered byte.
- R9: A 0-to-1 transition of `tx_en` during the stop bit or while the shifter is idle discards the buffered byte. `tx_empty` becomes 1 and the byte is never sent. A `wr` in the same clock still loads the buffer.
- R10: With `tx_inv` = 1, every level on `txd` is inverted: idle, start, data and stop.
- R11: `tx_done` is 1 exactly when the shifter is idle, the buffer is empty and no idle character is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-clock pulse per bit time |
| tx_en | input | 1 | Transmitter enable; rising transition schedules an idle character |
| nine_bit | input | 1 | 1 selects nine data bits per character |
| tx_inv | input | 1 | 1 inverts every level on the serial line |
| tie | input | 1 | Interrupt mask for the empty flag |
| wr | input | 1 | Write strobe for the holding buffer |
| din | input | W+1 | Data word; top bit is the ninth data bit |
| txd | output | 1 | Registered serial output line |
| tx_empty | output | 1 | Holding buffer is free |
| tx_done | output | 1 | Nothing left to send |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default data width of eight, so both the 10-bit and 11-bit character lengths are exercised. It drives a bit tick every fourth clock. That spacing is short enough that multi-character sequences finish quickly. It is also long enough to place an enable pulse between two specific ticks, either during the last data bit or during the stop bit. This brings the boundary between queueing an idle character (R8) and losing the buffered byte (R9) within reach.

// File: rtl/async_tx_core.sv
module async_tx_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         tx_en,
  input  logic         nine_bit,
  input  logic         tx_inv,
  input  logic         tie,
  input  logic         wr,
  input  logic [W:0]   din,
  output logic         txd,
  output logic         tx_empty,
  output logic         tx_done,
  output logic         irq
);
  localparam int SW = W + 3;
  localparam int CW = $clog2(SW + 1);

  logic [W:0]    hold;
  logic          full, en_q, pend, busy;
  logic [SW-1:0] sh;
  logic [CW-1:0] cnt;

  wire rise      = tx_en & ~en_q;
  wire last      = busy && (cnt == CW'(1));
  wire lose      = rise && (!busy || last);
  wire can_load  = bit_tick && tx_en && (!busy || last);
  wire take_idle = can_load && (pend || rise);
  wire take_data = can_load && !(pend || rise) && full;
  wire [CW-1:0] flen = nine_bit ? CW'(W + 3) : CW'(W + 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pend <= 1'b0;
      full <= 1'b0;
      busy <= 1'b0;
      sh   <= '1;
      cnt  <= '0;
      hold <= '0;
      txd  <= 1'b1;
    end else begin
      en_q <= tx_en;
      txd  <= (busy ? sh[0] : 1'b1) ^ tx_inv;
      if (rise) pend <= 1'b1;
      if (take_idle) begin
        sh   <= '1;
        cnt  <= flen;
        busy <= 1'b1;
        pend <= 1'b0;
      end else if (take_data) begin
        sh   <= {1'b1, (nine_bit ? hold[W] : 1'b1), hold[W-1:0], 1'b0};
        cnt  <= flen;
        busy <= 1'b1;
      end else if (bit_tick && busy) begin
        if (last) busy <= 1'b0;
        else begin
          sh  <= {1'b1, sh[SW-1:1]};
          cnt <= cnt - CW'(1);
        end
      end
      if (wr) begin
        hold <= din;
        full <= 1'b1;
      end else if (take_data || lose) begin
        full <= 1'b0;
      end
    end
  end

  assign tx_empty = ~full;
  assign tx_done  = ~busy & ~full & ~pend;
  assign irq      = tie & ~full;

  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> txd == ~$past(tx_inv));
  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !tx_empty);
  a_r7_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CW'(1) && cnt <= CW'(SW)));
  a_r9_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (lose && !wr) |=> tx_empty);
endmodule

// File: tb/sim_async_tx_core.sv
`timescale 1ns/1ps
module sim_async_tx_core;
  localparam int W  = 8;
  localparam int TK = 4;
  localparam int LM = 4096;
  localparam logic [10:0] VEC [6] = '{
    {9'h0A5, 1'b0, 1'b0}, {9'h13C, 1'b1, 1'b0}, {9'h05A, 1'b0, 1'b1},
    {9'h1C3, 1'b1, 1'b1}, {9'h100, 1'b0, 1'b0}, {9'h0FF, 1'b1, 1'b0}};

  logic clk = 0, rst_n = 0, bit_tick = 0, tx_en = 0, nine_bit = 0, tx_inv = 0, tie = 0, wr = 0;
  logic [W:0] din = '0;
  logic txd, tx_empty, tx_done, irq;
  int nchk = 0, nfail = 0, tcnt = 0, logn = 0, base = 0;
  logic logbits [LM];

  always #2 clk = ~clk;

  async_tx_core #(.W(W)) u0 (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .nine_bit(nine_bit), .tx_inv(tx_inv), .tie(tie), .wr(wr), .din(din),
    .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .irq(irq));

  always @(negedge clk) begin
    tcnt     <= (tcnt == TK - 1) ? 0 : tcnt + 1;
    bit_tick <= (tcnt == TK - 1);
    if (tcnt == 1) begin
      logbits[logn % LM] <= txd;
      logn <= logn + 1;
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #800000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk1;
    @(negedge clk); #1;
  endtask

  task automatic sync;
    do clk1(); while (tcnt != 1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) sync();
  endtask

  task automatic put(input logic [W:0] d);
    din = d; wr = 1; clk1(); wr = 0;
  endtask

  function automatic logic [15:0] frame(input logic [W:0] d, input logic nb, input logic inv);
    logic [15:0] f;
    f = '1; f[0] = 1'b0; f[8:1] = d[7:0];
    if (nb) f[9] = d[8];
    return f ^ {16{inv}};
  endfunction

  task automatic chk_bits(input int off, input int n, input logic [15:0] e, input string req);
    logic [15:0] a, m;
    a = '0; m = (16'h1 << n) - 16'h1;
    for (int i = 0; i < n; i++) a[i] = logbits[(base + off + i) % LM];
    chk(a == (e & m), req, int'(a), int'(e & m));
  endtask

  initial begin
    logic [10:0] v;
    int fl;
    tie = 1;
    repeat (3) clk1();
    rst_n = 1; clk1();
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(tx_empty == 1'b1, "R1 empty", tx_empty, 1);
    chk(tx_done == 1'b1, "R1 done", tx_done, 1);
    chk(irq == 1'b1, "R1 irq", irq, 1);

    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      tx_en = 0; nine_bit = v[1]; tx_inv = v[0]; tie = k[0];
      fl = v[1] ? 11 : 10;
      ticks(2);
      chk(txd == ~v[0], "R2 idle level", txd, ~v[0]);
      chk(irq == k[0], "R6 irq empty", irq, k[0]);
      sync(); base = logn;
      tx_en = 1; clk1();
      put(v[10:2]); clk1();
      chk(tx_empty == 0, "R5 write clears", tx_empty, 0);
      chk(irq == 0, "R6 irq full", irq, 0);
      ticks(2 * fl + 3);
      chk_bits(1, fl, 16'hFFFF ^ {16{v[0]}}, "R3/R10 preamble");
      chk_bits(fl + 1, fl, frame(v[10:2], v[1], v[0]), "R4/R10 frame");
      chk_bits(2 * fl + 1, 1, {16{~v[0]}}, "R2 after frame");
      chk(tx_done == 1, "R11 done", tx_done, 1);
    end

    tx_inv = 0; nine_bit = 0; tie = 0; fl = 10;
    tx_en = 0; clk1();
    sync(); base = logn;
    tx_en = 1; clk1(); put(9'h035);
    ticks(fl);
    chk(tx_empty == 0, "R5 before handoff", tx_empty, 0);
    ticks(1);
    chk(tx_empty == 1, "R5 at handoff", tx_empty, 1);
    put(9'h0C9);
    ticks(2 * fl + 2);
    chk_bits(fl + 1, fl, frame(9'h035, 0, 0), "R4 first");
    chk_bits(2 * fl + 1, fl, frame(9'h0C9, 0, 0), "R4 back-to-back");

    tx_en = 0; clk1();
    sync(); base = logn;
    tx_en = 1; clk1(); put(9'h035);
    ticks(fl + 1);
    tx_en = 0; put(9'h06C);
    ticks(3 * fl);
    chk_bits(fl + 1, fl, frame(9'h035, 0, 0), "R7 finishes");
    chk_bits(2 * fl + 1, fl, 16'hFFFF, "R7 idle after");
    chk(tx_empty == 0, "R7 byte held", tx_empty, 0);
    chk(tx_done == 0, "R7/R11 not done", tx_done, 0);
    sync(); base = logn;
    tx_en = 1; clk1(); clk1();
    chk(tx_empty == 1, "R9 idle discard", tx_empty, 1);
    ticks(2 * fl + 2);
    chk_bits(1, 2 * fl, 16'hFFFF, "R9 byte not sent");
    chk(tx_done == 1, "R11 done after", tx_done, 1);

    tx_en = 0; clk1();
    sync(); base = logn;
    tx_en = 1; clk1(); put(9'h096);
    ticks(fl + 1); put(9'h02D);
    ticks(fl - 2);
    tx_en = 0; clk1(); tx_en = 1; clk1();
    chk(tx_empty == 0, "R8 byte kept", tx_empty, 0);
    ticks(2 * fl + 4);
    chk_bits(fl + 1, fl, frame(9'h096, 0, 0), "R8 current");
    chk_bits(2 * fl + 1, fl, 16'hFFFF, "R8 queued idle");
    chk_bits(3 * fl + 1, fl, frame(9'h02D, 0, 0), "R8 byte after idle");

    tx_en = 0; clk1();
    sync(); base = logn;
    tx_en = 1; clk1(); put(9'h04B);
    ticks(fl + 1); put(9'h0E1);
    ticks(fl - 1);
    tx_en = 0; clk1(); tx_en = 1; clk1();
    chk(tx_empty == 1, "R9 stop discard", tx_empty, 1);
    ticks(2 * fl + 4);
    chk_bits(fl + 1, fl, frame(9'h04B, 0, 0), "R9 current");
    chk_bits(2 * fl + 1, fl, 16'hFFFF, "R9 idle");
    chk_bits(3 * fl + 1, fl, 16'hFFFF, "R9 lost byte");
    chk(tx_done == 1, "R11 final", tx_done, 1);

    tie = 1; clk1();
    chk(irq == 1, "R6 unmasked", irq, 1);
    report();
  end
endmodule